// File: doc/BRIEF.md
# Rectangle Block-Transfer Engine

This engine moves rectangles of bytes inside a linear byte-addressed video memory. A host loads its setup through a byte-wide register bus. The setup gives a source address, a pattern address and a destination address, a row stride for each, the width and height of the rectangle, the stepping direction on each axis, where the source operand comes from, a pixel size for the pattern and an 8-bit raster operation. A command write then starts the operation. The engine walks the rectangle one byte at a time. For each byte it fetches only the operands that the raster operation depends on, and then writes the result through a single-port memory port with a request/ready handshake.

Widths and heights are programmed as the value minus one. The direction bits let software copy overlapping regions safely by pointing both addresses at the last byte. A pattern with zero stride repeats one stored pixel over the whole rectangle, which gives a solid fill. The host polls a status register. It can suspend an operation and resume it later at the exact byte where it stopped, or terminate it.

Top module: `blit_engine`

## Requirements
- R1: After reset the status register reads 0x01 (ready, not busy) and mem_req is low.
- R2: The X count register holds bytes per row minus one and the Y count register holds rows minus one. An operation writes exactly (X+1)*(Y+1) destination bytes, with X as the inner loop, and writes no other byte.
- R3: The source and destination stride registers hold the row pitch minus one. Each new row starts at the previous row start plus or minus (stride+1).
- R4: Direction register 0x01 works per axis. Bit 0 set makes X step downward and bit 1 set makes rows step downward. The memory result equals in-order byte-by-byte processing, so overlapping moves come out correct when both addresses point at the last byte.
- R5: Route register 0x02 with value 4 takes the source operand from the pattern address stream. Any other value reads the source operand at the source address.
- R6: Result bit i equals rop[4*P[i] + 2*S[i] + D[i]], where rop is register 0x03. So 0xCC copies the source, 0xF0 the pattern, 0x66 gives source XOR destination, 0x00 gives zero and 0xFF gives ones.
- R7: The pattern address is the pattern row start plus a phase. The phase cycles 0..depth, where depth register 0x04 codes 0/1/2/3 mean 1/2/3/4-byte pixels, and it restarts on each row. The pattern row always advances upward by stride+1. A pattern stride of 0 keeps the same row. The direction bits do not act on the pattern.
- R8: The status register at 0x00 has bit 0 = ready (idle), bit 1 = busy (started and not yet finished or terminated) and bit 2 = suspended.
- R9: Writing 1 to 0x00 while busy removes mem_req from the next cycle on and keeps the position. Writing 0 then resumes, and the final memory equals that of an uninterrupted run.
- R10: Writing 2 to 0x00 ends the operation. From the next cycle mem_req is low and the status reads 0x01, and a later start runs normally.
- R11: The engine performs one memory read per byte for each of S, P and D that the raster operation depends on. The destination is read only when the result depends on D.
- R12: Register map: writing 0 to 0x00 while idle starts an operation. The source, pattern and destination addresses sit at 0x10, 0x14 and 0x18. The source, pattern and destination strides sit at 0x20, 0x22 and 0x24. The X count sits at 0x28 and the Y count at 0x2A. Each field is written low byte first at rising offsets. Read data is taken in the cycle where mem_req and mem_ready are both high, and a waiting request keeps its address and type until it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (status at 0x00, zero elsewhere) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Memory accepts the request this cycle |

## Verification
The bench builds the engine with ADDR_W=16, CNT_W=8 and STRIDE_W=8. This makes addresses two-byte fields and strides and counts single-byte fields, so a 4 KiB window of memory holds every rectangle, including overlapping ones stepping in both directions. With these widths, random rectangles up to 16x8 bytes, with every pixel depth, pattern stride and raster operation code, finish in a few hundred cycles each. That leaves room for stalls from a randomly withheld ready, and for suspend and terminate issued at arbitrary points of a walk.

// File: rtl/blit_pkg.sv
package blit_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD_S = 3'd1,
      ST_RD_P = 3'd2,
      ST_RD_D = 3'd3,
      ST_WR   = 3'd4
   } blit_state_e;

   // register offsets
   localparam int REG_CMD     = 0;
   localparam int REG_DIR     = 1;
   localparam int REG_ROUTE   = 2;
   localparam int REG_ROP     = 3;
   localparam int REG_DEPTH   = 4;
   localparam int REG_ADDR0   = 16;  // src, pat, dst every 4
   localparam int REG_STRIDE0 = 32;  // src, pat, dst every 2
   localparam int REG_CNT0    = 40;  // x, y every 2

   localparam logic [7:0] CMD_GO    = 8'd0;
   localparam logic [7:0] CMD_PAUSE = 8'd1;
   localparam logic [7:0] CMD_ABORT = 8'd2;
   localparam logic [7:0] ROUTE_PAT = 8'd4;

   function automatic logic rop_uses_s(input logic [7:0] rop);
      return (((rop >> 2) ^ rop) & 8'h33) != 8'h00;
   endfunction

   function automatic logic rop_uses_p(input logic [7:0] rop);
      return (((rop >> 4) ^ rop) & 8'h0F) != 8'h00;
   endfunction

   function automatic logic rop_uses_d(input logic [7:0] rop);
      return (((rop >> 1) ^ rop) & 8'h55) != 8'h00;
   endfunction

   // next fetch after finishing 'from' (IDLE/WR mean start of a byte)
   function automatic blit_state_e next_fetch(input logic [7:0] rop,
                                              input blit_state_e from);
      if ((from == ST_IDLE || from == ST_WR) && rop_uses_s(rop))
         return ST_RD_S;
      if (from != ST_RD_P && from != ST_RD_D && rop_uses_p(rop))
         return ST_RD_P;
      if (from != ST_RD_D && rop_uses_d(rop))
         return ST_RD_D;
      return ST_WR;
   endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs import blit_pkg::*; #(
   parameter int ADDR_W   = 24,
   parameter int CNT_W    = 16,
   parameter int STRIDE_W = 16,
   parameter int REG_AW   = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr,
   input  logic [REG_AW-1:0]                  waddr,
   input  logic [7:0]                         wdata,
   output logic [2:0][ADDR_W-1:0]             addr_o,
   output logic [2:0][STRIDE_W-1:0]           stride_o,
   output logic [1:0][CNT_W-1:0]              cnt_o,
   output logic [1:0]                         dir_o,
   output logic                               route_pat_o,
   output logic [7:0]                         rop_o,
   output logic [1:0]                         depth_o
);

   localparam int A_BYTES = ADDR_W / 8;
   localparam int S_BYTES = STRIDE_W / 8;
   localparam int C_BYTES = CNT_W / 8;

   for (genvar i = 0; i < 3; i++) begin : g_addr
      logic [ADDR_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (wr) begin
            for (int k = 0; k < A_BYTES; k++)
               if (waddr == REG_AW'(REG_ADDR0 + 4*i + k)) q[k*8 +: 8] <= wdata;
         end
      end
      assign addr_o[i] = q;
   end

   for (genvar i = 0; i < 3; i++) begin : g_stride
      logic [STRIDE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (wr) begin
            for (int k = 0; k < S_BYTES; k++)
               if (waddr == REG_AW'(REG_STRIDE0 + 2*i + k)) q[k*8 +: 8] <= wdata;
         end
      end
      assign stride_o[i] = q;
   end

   for (genvar i = 0; i < 2; i++) begin : g_cnt
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (wr) begin
            for (int k = 0; k < C_BYTES; k++)
               if (waddr == REG_AW'(REG_CNT0 + 2*i + k)) q[k*8 +: 8] <= wdata;
         end
      end
      assign cnt_o[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_o       <= '0;
         route_pat_o <= 1'b0;
         rop_o       <= 8'hCC;
         depth_o     <= '0;
      end else if (wr) begin
         if (waddr == REG_AW'(REG_DIR))   dir_o       <= wdata[1:0];
         if (waddr == REG_AW'(REG_ROUTE)) route_pat_o <= (wdata == ROUTE_PAT);
         if (waddr == REG_AW'(REG_ROP))   rop_o       <= wdata;
         if (waddr == REG_AW'(REG_DEPTH)) depth_o     <= wdata[1:0];
      end
   end

endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
   parameter int ADDR_W   = 24,
   parameter int CNT_W    = 16,
   parameter int STRIDE_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     step,
   input  logic [2:0][ADDR_W-1:0]   addr_i,
   input  logic [2:0][STRIDE_W-1:0] stride_i,
   input  logic [1:0][CNT_W-1:0]    cnt_i,
   input  logic [1:0]               dir_i,
   input  logic [1:0]               depth_i,
   output logic [ADDR_W-1:0]        src_o,
   output logic [ADDR_W-1:0]        pat_o,
   output logic [ADDR_W-1:0]        dst_o,
   output logic                     last_o
);

   logic [CNT_W-1:0]  x_lim, y_lim, x_cnt, y_cnt;
   logic [1:0]        dir_q, depth_q, phase_q;
   logic [ADDR_W-1:0] pat_row_q, pat_adv_q;
   logic              row_end, adv;
   logic [1:0][ADDR_W-1:0] mov;

   assign row_end = (x_cnt == x_lim);
   assign last_o  = row_end && (y_cnt == y_lim);
   assign adv     = step && !last_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_lim <= '0; y_lim <= '0; x_cnt <= '0; y_cnt <= '0;
         dir_q <= '0; depth_q <= '0;
      end else if (load) begin
         x_lim <= cnt_i[0]; y_lim <= cnt_i[1];
         x_cnt <= '0;       y_cnt <= '0;
         dir_q <= dir_i;    depth_q <= depth_i;
      end else if (adv) begin
         if (row_end) begin
            x_cnt <= '0;
            y_cnt <= y_cnt + 1'b1;
         end else begin
            x_cnt <= x_cnt + 1'b1;
         end
      end
   end

   // source (0) and destination (1) walk with the direction bits
   for (genvar g = 0; g < 2; g++) begin : g_mov
      localparam int SEL = g * 2;
      logic [ADDR_W-1:0] row_q, cur_q, pitch_q, next_row;
      assign next_row = dir_q[1] ? (row_q - pitch_q) : (row_q + pitch_q);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_q <= '0; cur_q <= '0; pitch_q <= '0;
         end else if (load) begin
            row_q   <= addr_i[SEL];
            cur_q   <= addr_i[SEL];
            pitch_q <= ADDR_W'(stride_i[SEL]) + ADDR_W'(1);
         end else if (adv) begin
            if (row_end) begin
               row_q <= next_row;
               cur_q <= next_row;
            end else begin
               cur_q <= dir_q[0] ? (cur_q - ADDR_W'(1)) : (cur_q + ADDR_W'(1));
            end
         end
      end
      assign mov[g] = cur_q;
   end

   assign src_o = mov[0];
   assign dst_o = mov[1];

   // pattern walks forward only, phase wraps every pixel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_row_q <= '0; pat_adv_q <= '0; phase_q <= '0;
      end else if (load) begin
         pat_row_q <= addr_i[1];
         pat_adv_q <= (stride_i[1] == '0) ? '0 : ADDR_W'(stride_i[1]) + ADDR_W'(1);
         phase_q   <= '0;
      end else if (adv) begin
         if (row_end) begin
            pat_row_q <= pat_row_q + pat_adv_q;
            phase_q   <= '0;
         end else begin
            phase_q <= (phase_q == depth_q) ? 2'd0 : phase_q + 2'd1;
         end
      end
   end

   assign pat_o = pat_row_q + ADDR_W'(phase_q);

   a_r2_x_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      x_cnt <= x_lim);
   a_r2_y_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      y_cnt <= y_lim);
   a_r7_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= depth_q);

endmodule

// File: rtl/blit_rop_alu.sv
module blit_rop_alu #(
   parameter int LANE_W = 8
) (
   input  logic [7:0]        rop,
   input  logic [LANE_W-1:0] pat,
   input  logic [LANE_W-1:0] src,
   input  logic [LANE_W-1:0] dst,
   output logic [LANE_W-1:0] res
);

   for (genvar i = 0; i < LANE_W; i++) begin : g_bit
      assign res[i] = rop[{pat[i], src[i], dst[i]}];
   end

endmodule

// File: rtl/blit_engine.sv
module blit_engine import blit_pkg::*; #(
   parameter int ADDR_W   = 24,
   parameter int CNT_W    = 16,
   parameter int STRIDE_W = 16,
   parameter int REG_AW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ready
);

   if (ADDR_W % 8 != 0 || ADDR_W < 8 || ADDR_W > 24) begin : g_bad_aw
      $error("ADDR_W must be 8, 16 or 24");
   end
   if (CNT_W % 8 != 0 || CNT_W < 8 || CNT_W > 16) begin : g_bad_cw
      $error("CNT_W must be 8 or 16");
   end
   if (STRIDE_W % 8 != 0 || STRIDE_W < 8 || STRIDE_W > 16 || STRIDE_W > ADDR_W) begin : g_bad_sw
      $error("STRIDE_W must be 8 or 16 and not exceed ADDR_W");
   end
   if (REG_AW < 6) begin : g_bad_ra
      $error("REG_AW must reach offset 0x2B");
   end

   logic [2:0][ADDR_W-1:0]   cfg_addr;
   logic [2:0][STRIDE_W-1:0] cfg_stride;
   logic [1:0][CNT_W-1:0]    cfg_cnt;
   logic [1:0]               cfg_dir, cfg_depth;
   logic                     cfg_route_pat;
   logic [7:0]               cfg_rop;

   blit_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_addr), .wdata(reg_wdata),
      .addr_o(cfg_addr), .stride_o(cfg_stride), .cnt_o(cfg_cnt), .dir_o(cfg_dir),
      .route_pat_o(cfg_route_pat), .rop_o(cfg_rop), .depth_o(cfg_depth));

   blit_state_e state_q;
   logic        paused_q, route_pat_q, active, xfer, load, step, last;
   logic [7:0]  rop_q, s_q, p_q, d_q, res;
   logic        cmd_wr, go_cmd, pause_cmd, abort_cmd;
   logic [ADDR_W-1:0] src_a, pat_a, dst_a;

   assign cmd_wr    = reg_wr && (reg_addr == REG_AW'(REG_CMD));
   assign go_cmd    = cmd_wr && (reg_wdata == CMD_GO);
   assign pause_cmd = cmd_wr && (reg_wdata == CMD_PAUSE);
   assign abort_cmd = cmd_wr && (reg_wdata == CMD_ABORT);

   assign active  = (state_q != ST_IDLE);
   assign mem_req = active && !paused_q;
   assign mem_we  = (state_q == ST_WR);
   assign xfer    = mem_req && mem_ready;
   assign load    = go_cmd && !active;
   assign step    = xfer && (state_q == ST_WR);

   blit_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) u_agen (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .addr_i(cfg_addr), .stride_i(cfg_stride), .cnt_i(cfg_cnt),
      .dir_i(cfg_dir), .depth_i(cfg_depth),
      .src_o(src_a), .pat_o(pat_a), .dst_o(dst_a), .last_o(last));

   blit_rop_alu #(.LANE_W(8)) u_alu (
      .rop(rop_q), .pat(p_q), .src(s_q), .dst(d_q), .res(res));

   always_comb begin
      unique case (state_q)
         ST_RD_S: mem_addr = route_pat_q ? pat_a : src_a;
         ST_RD_P: mem_addr = pat_a;
         default: mem_addr = dst_a;
      endcase
   end

   assign mem_wdata = res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         paused_q    <= 1'b0;
         rop_q       <= 8'h00;
         route_pat_q <= 1'b0;
         s_q <= '0; p_q <= '0; d_q <= '0;
      end else if (abort_cmd) begin
         state_q  <= ST_IDLE;
         paused_q <= 1'b0;
      end else if (load) begin
         state_q     <= next_fetch(cfg_rop, ST_IDLE);
         rop_q       <= cfg_rop;
         route_pat_q <= cfg_route_pat;
         paused_q    <= 1'b0;
      end else begin
         if (go_cmd)                  paused_q <= 1'b0;
         else if (pause_cmd && active) paused_q <= 1'b1;
         if (xfer) begin
            unique case (state_q)
               ST_RD_S: begin s_q <= mem_rdata; state_q <= next_fetch(rop_q, ST_RD_S); end
               ST_RD_P: begin p_q <= mem_rdata; state_q <= next_fetch(rop_q, ST_RD_P); end
               ST_RD_D: begin d_q <= mem_rdata; state_q <= ST_WR; end
               ST_WR:   state_q <= last ? ST_IDLE : next_fetch(rop_q, ST_WR);
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign reg_rdata = (reg_addr == REG_AW'(REG_CMD)) ?
                      {5'b0, paused_q, active, !active} : 8'h00;

   a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      abort_cmd |=> !mem_req && reg_rdata[1] == 1'b0);
   a_r9_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_cmd && active) |=> !mem_req);
   a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready && !cmd_wr) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
   a_r8_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req && !paused_q |-> (reg_addr != REG_AW'(REG_CMD)) || (reg_rdata[0] != reg_rdata[1]));

endmodule

// File: tb/test_blit_engine.sv
`timescale 1ns/1ps
module test_blit_engine;

   localparam int AW = 16, CW = 8, SW = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, reg_wr, mem_req, mem_we, mem_ready;
   logic [7:0]    reg_addr, reg_wdata, reg_rdata, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;

   blit_engine #(.ADDR_W(AW), .CNT_W(CW), .STRIDE_W(SW), .REG_AW(8)) i_blit_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready));

   logic [7:0] mem  [4096];
   logic [7:0] refm [4096];
   int rd_cnt = 0, wr_cnt = 0, checks = 0, errors = 0;
   bit rand_ready = 1'b0;

   int op_src, op_pat, op_dst, op_ss, op_ps, op_ds, op_xc, op_yc;
   int op_dir, op_route, op_rop, op_depth;

   assign mem_rdata = mem[mem_addr[11:0]];

   always @(posedge clk)
      if (mem_req && mem_ready) begin
         if (mem_we) begin mem[mem_addr[11:0]] <= mem_wdata; wr_cnt++; end
         else rd_cnt++;
      end

   always @(negedge clk) mem_ready <= rand_ready ? (($urandom % 4) != 0) : 1'b1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input int a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = 8'(a);
      #1 d = reg_rdata;
   endtask

   // R12 register map, low byte first
   task automatic program_op();
      for (int k = 0; k < 2; k++) begin
         reg_write(16 + k, op_src >> (8*k));
         reg_write(20 + k, op_pat >> (8*k));
         reg_write(24 + k, op_dst >> (8*k));
      end
      reg_write(32, op_ss); reg_write(34, op_ps); reg_write(36, op_ds);
      reg_write(40, op_xc); reg_write(42, op_yc);
      reg_write(1, op_dir); reg_write(2, op_route);
      reg_write(3, op_rop); reg_write(4, op_depth);
   endtask

   function automatic bit depends(input int rop, input int sh);
      for (int idx = 0; idx < 8; idx++)
         if (rop[idx] != rop[idx ^ sh]) return 1'b1;
      return 1'b0;
   endfunction

   // in-order model from R2..R7
   task automatic ref_model();
      int srow, drow, prow, sa, da, ph;
      logic [7:0] s, p, d, r;
      srow = op_src; drow = op_dst; prow = op_pat;
      for (int y = 0; y <= op_yc; y++) begin
         sa = srow; da = drow; ph = 0;
         for (int x = 0; x <= op_xc; x++) begin
            p = refm[(prow + ph) & 12'hFFF];
            s = (op_route == 4) ? p : refm[sa & 12'hFFF];
            d = refm[da & 12'hFFF];
            for (int b = 0; b < 8; b++) r[b] = op_rop[{p[b], s[b], d[b]}];
            refm[da & 12'hFFF] = r;
            ph = (ph == op_depth) ? 0 : ph + 1;
            sa = op_dir[0] ? sa - 1 : sa + 1;
            da = op_dir[0] ? da - 1 : da + 1;
         end
         srow = op_dir[1] ? srow - (op_ss + 1) : srow + (op_ss + 1);
         drow = op_dir[1] ? drow - (op_ds + 1) : drow + (op_ds + 1);
         prow = (op_ps == 0) ? prow : prow + op_ps + 1;
      end
   endtask

   task automatic wait_idle();
      logic [7:0] st;
      int n = 0;
      do begin reg_read(0, st); n++; end while (st[1] && n < 20000);
   endtask

   task automatic compare(input string req);
      int bad = 0, first = 0;
      for (int a = 0; a < 4096; a++)
         if (mem[a] !== refm[a]) begin
            if (bad == 0) first = a;
            bad++;
         end
      check(bad == 0, req, int'(mem[first]), int'(refm[first]));
   endtask

   task automatic run_check(input string req);
      int r0, per;
      for (int a = 0; a < 4096; a++) refm[a] = mem[a];
      ref_model();
      program_op();
      r0 = rd_cnt;
      reg_write(0, 0);
      wait_idle();
      compare(req);
      per = int'(depends(op_rop, 2)) + int'(depends(op_rop, 4)) + int'(depends(op_rop, 1));
      check(rd_cnt - r0 == per * (op_xc + 1) * (op_yc + 1), {req, " R11 reads"},
            rd_cnt - r0, per * (op_xc + 1) * (op_yc + 1));
   endtask

   task automatic set_op(input int s, input int p, input int d, input int ss, input int ps,
                         input int ds, input int xc, input int yc, input int dir,
                         input int route, input int rop, input int depth);
      op_src = s; op_pat = p; op_dst = d; op_ss = ss; op_ps = ps; op_ds = ds;
      op_xc = xc; op_yc = yc; op_dir = dir; op_route = route; op_rop = rop; op_depth = depth;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] st;
      int c0;
      void'($urandom(32'h5EED));
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
      for (int a = 0; a < 4096; a++) mem[a] = 8'($urandom);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R8 reset state
      reg_read(0, st);
      check(st == 8'h01, "R1 status after reset", st, 1);
      check(mem_req == 1'b0, "R1 no request after reset", mem_req, 0);

      // R2 R3 plain copy, pitch 32
      set_op('h100, 'hC00, 'h300, 31, 0, 31, 4, 2, 0, 0, 'hCC, 0);
      run_check("R2 R3 forward copy");
      // R7 solid fill from 3-byte pixel, stride 0
      set_op('h100, 'hC10, 'h400, 31, 0, 31, 9, 3, 0, 0, 'hF0, 2);
      run_check("R7 pattern fill depth 2");
      // R5 route 4 takes source from pattern, 4-byte pixel
      set_op('h100, 'hC20, 'h500, 31, 0, 31, 7, 2, 0, 4, 'hCC, 3);
      run_check("R5 pattern routed source");
      // R6 xor with destination
      set_op('h180, 'hC00, 'h580, 15, 0, 15, 5, 3, 0, 0, 'h66, 0);
      run_check("R6 source xor dest");
      // R6 constants
      set_op('h180, 'hC00, 'h600, 15, 0, 15, 3, 1, 0, 0, 'h00, 0);
      run_check("R6 zero");
      set_op('h180, 'hC00, 'h640, 15, 0, 15, 3, 1, 0, 0, 'hFF, 0);
      run_check("R6 ones");
      // R4 overlap, dest one row down and one right, both axes decreasing
      set_op('h700 + 3*32 + 7, 'hC00, 'h700 + 3*32 + 7 + 33, 31, 0, 31, 7, 3, 3, 0, 'hCC, 0);
      run_check("R4 overlap both axes");
      // R4 overlap within rows, X decreasing only
      set_op('h800 + 7, 'hC00, 'h800 + 8, 31, 0, 31, 7, 2, 1, 0, 'hCC, 0);
      run_check("R4 overlap x only");
      // R7 non-zero pattern stride
      set_op('h100, 'hC40, 'h900, 31, 7, 31, 5, 3, 0, 0, 'hF0, 1);
      run_check("R7 pattern stride");

      // random mix with stalls
      for (int it = 0; it < 12; it++) begin
         rand_ready = it[0];
         set_op('h300 + int'($urandom % 'h400), 'hC00 + int'($urandom % 'h100),
                'h300 + int'($urandom % 'h400), 15 + int'($urandom % 26),
                (($urandom % 2) == 0) ? 0 : int'($urandom % 21), 15 + int'($urandom % 26),
                int'($urandom % 16), int'($urandom % 8), int'($urandom % 4),
                (($urandom % 2) == 0) ? 0 : 4, int'($urandom % 256), int'($urandom % 4));
         run_check("R2 R6 random");
      end

      // R9 suspend and resume
      rand_ready = 1'b0;
      set_op('h100, 'hC00, 'h900, 31, 0, 31, 15, 7, 0, 0, 'h66, 0);
      for (int a = 0; a < 4096; a++) refm[a] = mem[a];
      ref_model();
      program_op();
      reg_write(0, 0);
      repeat (20) @(negedge clk);
      reg_read(0, st);
      check(st == 8'h02, "R8 busy while running", st, 2);
      reg_write(0, 1);
      repeat (2) @(negedge clk);
      reg_read(0, st);
      check(st == 8'h06, "R8 suspended status", st, 6);
      c0 = rd_cnt + wr_cnt;
      repeat (30) @(negedge clk);
      check(rd_cnt + wr_cnt == c0, "R9 no access while suspended", rd_cnt + wr_cnt, c0);
      reg_write(0, 0);
      wait_idle();
      compare("R9 resume result");

      // R10 terminate
      set_op('h100, 'hC00, 'hA00, 31, 0, 31, 15, 7, 0, 0, 'hCC, 0);
      program_op();
      reg_write(0, 0);
      repeat (10) @(negedge clk);
      reg_write(0, 2);
      reg_read(0, st);
      check(st == 8'h01, "R10 idle after terminate", st, 1);
      c0 = rd_cnt + wr_cnt;
      repeat (20) @(negedge clk);
      check(rd_cnt + wr_cnt == c0, "R10 no access after terminate", rd_cnt + wr_cnt, c0);
      set_op('h120, 'hC00, 'hB00, 31, 0, 31, 6, 2, 0, 0, 'hCC, 0);
      run_check("R10 restart after terminate");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule